// File: doc/BRIEF.md
# Free-Running Counter Timer with One Compare Channel

The block keeps a 64-bit count that steps once for every cycle in which the timer tick input is high. Software sees that count as two 32-bit words on a single-cycle register port. A read returns data in the same cycle as the address. A write takes effect at the next clock edge. The high word moves on the same edge as the low-word rollover, so a carry is never seen half done. Software reads high, low, then high again, and keeps the result when the two high reads agree.

One compare channel watches only the low word. To arm it, software writes `compare = low + delta` and sets the enable. A delta from 6 up to 2^32-1 works, because the 32-bit sum wraps together with the low word. A hit is taken when a tick moves the low word onto the compare value while the enable is on. The hit sets a sticky status flag in the same edge, so a read that shows the counter at the compare value also shows the flag.

The enable and the flag are held as one four-state machine, encoded {enable, flag}:
- **OFF**: enable off, flag clear.
- **ARMED**: enable on, flag clear.
- **HIT**: enable on, flag set. This is the only state that drives the interrupt.
- **HELD**: enable off, flag set.

Its transitions:
- **arm**: a control write with the enable bit set.
- **disarm**: a control write with the enable bit clear.
- **match**: a hit. ARMED goes to HIT.
- **acknowledge**: a write of 1 to the flag bit. HIT goes to ARMED, and HELD goes to OFF.

Arm and disarm also move HELD to HIT and HIT to HELD. A match that lands in the same edge as an acknowledge keeps the flag set.

Top module: `cmp_timer`

## Requirements
- R1: After reset the following all read zero: the control word (offset 0x0), the compare register (0x0C) and `irq`. Both counter words (low at 0x4, high at 0x8) read the parameter `INIT_COUNT`, which defaults to zero.
- R2: The counter rises by exactly one at each clock edge where `tick` is high. It holds its value when `tick` is low.
- R3: When the low word steps from 0xFFFFFFFF to 0, the high word rises by one at that same edge.
- R4: A hit is an edge where the enable is on, `tick` is high and the incremented low word equals the compare value. A hit sets the flag (control bit 0) at that edge. This includes a compare value reached by wrapping past zero.
- R5: While the enable is off, the flag is never set, whatever the counter and compare values.
- R6: The flag stays set until a control write with bit 0 = 1. A control write with bit 0 = 0 leaves it unchanged.
- R7: A control write loads the enable (control bit 4) from bit 4 of the write data. `irq` is high exactly when the flag and the enable are both set. Clearing the enable drops `irq` but keeps the flag.
- R8: When a hit and a flag-clearing control write fall on the same edge, the flag stays set.
- R9: The compare register at 0x0C reads back what was written. Writes to the counter words have no effect. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt: flag and enable |

## Verification
Read data is due in the cycle the address is applied, so the monitor compares it 1 ns after the driver sets the address at a falling edge. A write, a tick or a match becomes visible after exactly one rising edge. Every step task therefore moves on whole clock periods and returns at a falling edge before the next read is queued. The expected counter, flag, enable and `irq` values come from counting the rising edges each task spans.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int OFS_CTRL  = 'h0;
    localparam int OFS_CNTLO = 'h4;
    localparam int OFS_CNTHI = 'h8;
    localparam int OFS_CMP   = 'hC;

    localparam int BIT_FLAG  = 0;
    localparam int BIT_EN    = 4;

    // encoding is {enable, flag}
    typedef enum logic [1:0] {
        CH_OFF   = 2'b00,
        CH_HELD  = 2'b01,
        CH_ARMED = 2'b10,
        CH_HIT   = 2'b11
    } ch_state_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned LO_W  = 32,
    parameter logic [CNT_W-1:0] INIT_COUNT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [LO_W-1:0] cnt_lo,
    output logic [CNT_W-LO_W-1:0] cnt_hi,
    output logic [LO_W-1:0] lo_next
);
    localparam int unsigned HI_W = CNT_W - LO_W;

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            carry;

    assign carry   = &lo_q;
    assign lo_next = lo_q + LO_W'(1);
    assign cnt_lo  = lo_q;
    assign cnt_hi  = hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= INIT_COUNT[LO_W-1:0];
            hi_q <= INIT_COUNT[CNT_W-1:LO_W];
        end else if (tick) begin
            lo_q <= lo_next;
            if (carry) hi_q <= hi_q + HI_W'(1);
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(lo_q) && $stable(hi_q))); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !carry) |=> (lo_q == $past(lo_q) + LO_W'(1) && $stable(hi_q))); // R2
    AST_CARRY_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && carry) |=> (lo_q == '0 && hi_q == $past(hi_q) + HI_W'(1))); // R3
endmodule

// File: rtl/tmr_cmp_fsm.sv
module tmr_cmp_fsm
    import tmr_pkg::*;
#(
    parameter int unsigned LO_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [LO_W-1:0] lo_next,
    input  logic [LO_W-1:0] cmp_val,
    input  logic            ctl_wr,
    input  logic            wr_en_bit,
    input  logic            wr_clr_bit,
    output logic            en,
    output logic            flag,
    output logic            irq
);
    ch_state_t state_q, state_n;
    logic      hit, en_n, flag_n;

    // the match uses the enable held before any write in this cycle
    assign hit = state_q[1] && tick && (lo_next == cmp_val);

    always_comb begin
        en_n   = ctl_wr ? wr_en_bit : state_q[1];
        flag_n = hit || (state_q[0] && !(ctl_wr && wr_clr_bit));
        unique case ({en_n, flag_n})
            2'b00:   state_n = CH_OFF;
            2'b01:   state_n = CH_HELD;
            2'b10:   state_n = CH_ARMED;
            default: state_n = CH_HIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            CH_OFF:   begin en = 1'b0; flag = 1'b0; irq = 1'b0; end
            CH_HELD:  begin en = 1'b0; flag = 1'b1; irq = 1'b0; end
            CH_ARMED: begin en = 1'b1; flag = 1'b0; irq = 1'b0; end
            default:  begin en = 1'b1; flag = 1'b1; irq = 1'b1; end
        endcase
    end

    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R4
    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !en) |=> !flag); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(ctl_wr && wr_clr_bit)) |=> flag); // R6
    AST_EN_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (en == $past(wr_en_bit))); // R7
    AST_MATCH_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctl_wr && wr_clr_bit) |=> flag); // R8
endmodule

// File: rtl/tmr_regmux.sv
module tmr_regmux
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HI_W   = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic              flag,
    input  logic [DATA_W-1:0] cnt_lo,
    input  logic [HI_W-1:0]   cnt_hi,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CTRL)) begin
            rdata[BIT_FLAG] = flag;
            rdata[BIT_EN]   = en;
        end else if (addr == ADDR_W'(OFS_CNTLO)) begin
            rdata = cnt_lo;
        end else if (addr == ADDR_W'(OFS_CNTHI)) begin
            rdata = DATA_W'(cnt_hi);
        end else if (addr == ADDR_W'(OFS_CMP)) begin
            rdata = cmp_val;
        end
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 64,
    parameter logic [CNT_W-1:0] INIT_COUNT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int unsigned HI_W = CNT_W - DATA_W;

    logic [DATA_W-1:0] cnt_lo, lo_next, cmp_q;
    logic [HI_W-1:0]   cnt_hi;
    logic              en, flag, ctl_wr, cmp_wr;

    assign ctl_wr = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign cmp_wr = bus_we && (bus_addr == ADDR_W'(OFS_CMP));

    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_wr) cmp_q <= bus_wdata;
    end

    tmr_counter #(.CNT_W(CNT_W), .LO_W(DATA_W), .INIT_COUNT(INIT_COUNT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .lo_next(lo_next)
    );

    tmr_cmp_fsm #(.LO_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .lo_next(lo_next), .cmp_val(cmp_q),
        .ctl_wr(ctl_wr), .wr_en_bit(bus_wdata[BIT_EN]), .wr_clr_bit(bus_wdata[BIT_FLAG]),
        .en(en), .flag(flag), .irq(irq)
    );

    tmr_regmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_W(HI_W)) u_mux (
        .addr(bus_addr), .en(en), .flag(flag),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cmp_val(cmp_q),
        .rdata(bus_rdata)
    );

    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> (cmp_q == $past(bus_wdata))); // R9
    AST_CMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_wr |=> $stable(cmp_q)); // R9
endmodule

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0]  a;
        logic [31:0] d;
        logic        i;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    cmp_timer #(.INIT_COUNT(64'h0000_0001_FFFF_FFF0)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: compares one queued item once the driver has applied its address
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            #1;
            begin
                exp_t it;
                it = sb_q.pop_front();
                n_vec++;
                if (bus_rdata !== it.d || irq !== it.i) begin
                    n_bad++;
                    $display("FAIL %s addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
                             it.tag, it.a, bus_rdata, irq, it.d, it.i);
                end
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [31:0] d, input logic i, input string tag);
        exp_t it;
        @(negedge clk);
        bus_addr = a;
        it.a = a; it.d = d; it.i = i; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    // one edge carrying both a tick and a control write
    task automatic tick_and_ctl(input logic [31:0] d);
        @(negedge clk);
        tick = 1'b1; bus_addr = 4'h0; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        tick = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(4'h0, 32'h0, 1'b0, "R1 ctrl");
        rd(4'h4, 32'hFFFF_FFF0, 1'b0, "R1 low");
        rd(4'h8, 32'h1, 1'b0, "R1 high");
        rd(4'hC, 32'h0, 1'b0, "R1 compare");

        run(5);
        rd(4'h4, 32'hFFFF_FFF5, 1'b0, "R2 five ticks");
        repeat (4) @(negedge clk);
        rd(4'h4, 32'hFFFF_FFF5, 1'b0, "R2 hold without tick");

        wr(4'hC, 32'hFFFF_FFFB);
        wr(4'h0, 32'h10);
        rd(4'h0, 32'h10, 1'b0, "R7 enable set");
        run(5);
        rd(4'h0, 32'h10, 1'b0, "R4 one before match");
        run(1);
        rd(4'h4, 32'hFFFF_FFFB, 1'b1, "R4 low at compare");
        rd(4'h0, 32'h11, 1'b1, "R4 flag on match");
        run(3);
        rd(4'h0, 32'h11, 1'b1, "R6 flag sticky");
        wr(4'h0, 32'h10);
        rd(4'h0, 32'h11, 1'b1, "R6 write zero keeps flag");
        wr(4'h0, 32'h11);
        rd(4'h0, 32'h10, 1'b0, "R6 write one clears");

        wr(4'hC, 32'h4);
        run(1);
        rd(4'h4, 32'hFFFF_FFFF, 1'b0, "R3 low at top");
        rd(4'h8, 32'h1, 1'b0, "R3 high before carry");
        run(1);
        rd(4'h4, 32'h0, 1'b0, "R3 low wrapped");
        rd(4'h8, 32'h2, 1'b0, "R3 high carried");
        run(3);
        rd(4'h0, 32'h10, 1'b0, "R4 wrap not yet");
        run(1);
        rd(4'h0, 32'h11, 1'b1, "R4 wrapped match");

        wr(4'h0, 32'h00);
        rd(4'h0, 32'h01, 1'b0, "R7 disable keeps flag, irq low");
        wr(4'h0, 32'h10);
        rd(4'h0, 32'h11, 1'b1, "R7 re-enable raises irq");
        wr(4'h0, 32'h11);
        rd(4'h0, 32'h10, 1'b0, "R6 clear again");

        wr(4'h0, 32'h00);
        wr(4'hC, 32'h7);
        run(5);
        rd(4'h4, 32'h9, 1'b0, "R5 counter passed compare");
        rd(4'h0, 32'h00, 1'b0, "R5 no flag while disabled");

        wr(4'hC, 32'hB);
        wr(4'h0, 32'h10);
        run(2);
        rd(4'h0, 32'h11, 1'b1, "R8 setup flag");
        wr(4'hC, 32'hC);
        tick_and_ctl(32'h11);
        rd(4'h4, 32'hC, 1'b1, "R8 low at second compare");
        rd(4'h0, 32'h11, 1'b1, "R8 match beats clear");
        wr(4'h0, 32'h11);
        rd(4'h0, 32'h10, 1'b0, "R8 plain clear after");

        wr(4'h4, 32'h1234_5678);
        wr(4'h8, 32'hDEAD_BEEF);
        rd(4'h4, 32'hC, 1'b0, "R9 low read-only");
        rd(4'h8, 32'h2, 1'b0, "R9 high read-only");
        rd(4'hC, 32'hC, 1'b0, "R9 compare readback");
        rd(4'h2, 32'h0, 1'b0, "R9 unmapped reads zero");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired rdata=%h irq=%b expected completion", bus_rdata, irq);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule